// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a simple clocked request port and an asynchronous static RAM that has separate data-in and data-out pins. A client presents a request (read or write, address, write data) while the controller is idle. The controller then runs the memory strobes through a fixed sequence of phases. Each phase length is a parameter counted in clock cycles, obtained by dividing a nanosecond limit of the memory by the clock period and rounding up. Every count is at least one cycle.

A write drives chip select low and holds write enable high for an address setup phase. Write enable then goes low for a pulse phase whose length is the larger of the write pulse width and the data setup time. A recovery phase follows, with write enable high again and chip select still low. Output enable stays high during the whole write. A read drives chip select and output enable low for an access phase and samples the memory output at the clock edge that ends that phase. A write that follows a read first runs a turnaround phase with every strobe inactive. The ready output pulses once when an operation completes. A new request may be presented in that same cycle, so operations can run back to back.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: While reset is applied and in the first cycle after it, mem_cs_n, mem_we_n and mem_oe_n are 1 and ready is 0.
- R2: A request is taken only in a cycle where the controller is idle. A req raised while an operation is in progress is ignored: it produces no ready pulse and writes nothing into the memory.
- R3: A write keeps mem_cs_n at 0 for exactly T_ASU + max(T_WP, T_DSU) + T_REC consecutive cycles. Within that window, mem_we_n is 1 for the first T_ASU cycles, 0 for the next max(T_WP, T_DSU) cycles, and 1 for the last T_REC cycles. mem_addr and mem_dout do not change while mem_cs_n is 0.
- R4: mem_oe_n is 1 in every cycle of a write, and mem_we_n is 0 only while mem_cs_n is 0.
- R5: A read holds mem_cs_n and mem_oe_n at 0 and mem_we_n at 1 for exactly T_ACC cycles. rdata takes the value of mem_din sampled at the clock edge that ends the last of those cycles.
- R6: ready is a pulse one cycle wide in the first idle cycle after an operation. rdata keeps its value until the next read completes.
- R7: Between two operations mem_cs_n is 1 for at least one cycle. A request raised in the ready cycle is accepted at the next edge, and the strobes for a read, or for a write that follows a write, become active in the cycle after that edge.
- R8: A write accepted right after a read first spends T_TURN cycles with mem_cs_n, mem_we_n and mem_oe_n at 1. Counting from the accepting edge, its ready pulse is then seen T_TURN + T_ASU + max(T_WP, T_DSU) + T_REC cycles later, while a read's ready is seen T_ACC cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req | input | 1 | Request, taken when the controller is idle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | AW | Request address |
| wdata | input | DW | Write data |
| rdata | output | DW | Captured read data |
| ready | output | 1 | One-cycle completion pulse |
| mem_addr | output | AW | Address to the memory |
| mem_dout | output | DW | Data to the memory data-in pins |
| mem_din | input | DW | Data from the memory data-out pins |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |

## Verification
The bench builds the controller with 8-bit address and data and with phase counts T_ASU=2, T_WP=3, T_DSU=4, T_REC=2, T_ACC=3 and T_TURN=2. Because the data setup count exceeds the pulse count, the pulse length must come from the data setup count. Because every phase is longer than one cycle, a phase that is one cycle short or one cycle long changes the measured lengths and the latency. The memory model returns a garbage pattern until chip select and output enable have been low for T_ACC-1 edges, so a read sampled early is caught.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_WADDR,
        ST_WPULSE,
        ST_WREC,
        ST_RACC
    } ctl_state_e;

    typedef struct packed {
        ctl_state_e state;
        logic       last_rd;
        logic       cs_n;
        logic       we_n;
        logic       oe_n;
        logic       ready;
    } seq_regs_t;

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expire
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val - CW'(1);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expire = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int T_ASU  = 1,
    parameter int T_WP   = 1,
    parameter int T_DSU  = 1,
    parameter int T_REC  = 1,
    parameter int T_ACC  = 2,
    parameter int T_TURN = 1,
    parameter int CW     = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          we,
    input  logic          tmr_expire,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output logic          accept,
    output logic          capture,
    output logic          cs_n,
    output logic          we_n,
    output logic          oe_n,
    output logic          ready
);

    localparam int WPLEN = (T_WP > T_DSU) ? T_WP : T_DSU;

    seq_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.ready = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        accept   = 1'b0;
        capture  = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (req) begin
                    accept      = 1'b1;
                    tmr_load    = 1'b1;
                    r_d.last_rd = !we;
                    if (we) begin
                        if (r_q.last_rd) begin
                            r_d.state = ST_TURN;
                            tmr_val   = CW'(T_TURN);
                        end else begin
                            r_d.state = ST_WADDR;
                            tmr_val   = CW'(T_ASU);
                        end
                    end else begin
                        r_d.state = ST_RACC;
                        tmr_val   = CW'(T_ACC);
                    end
                end
            end
            ST_TURN: begin
                if (tmr_expire) begin
                    r_d.state = ST_WADDR;
                    tmr_load  = 1'b1;
                    tmr_val   = CW'(T_ASU);
                end
            end
            ST_WADDR: begin
                if (tmr_expire) begin
                    r_d.state = ST_WPULSE;
                    tmr_load  = 1'b1;
                    tmr_val   = CW'(WPLEN);
                end
            end
            ST_WPULSE: begin
                if (tmr_expire) begin
                    r_d.state = ST_WREC;
                    tmr_load  = 1'b1;
                    tmr_val   = CW'(T_REC);
                end
            end
            ST_WREC: begin
                if (tmr_expire) begin
                    r_d.state = ST_IDLE;
                    r_d.ready = 1'b1;
                end
            end
            ST_RACC: begin
                if (tmr_expire) begin
                    r_d.state = ST_IDLE;
                    r_d.ready = 1'b1;
                    capture   = 1'b1;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
        r_d.cs_n = (r_d.state == ST_IDLE) || (r_d.state == ST_TURN);
        r_d.we_n = (r_d.state != ST_WPULSE);
        r_d.oe_n = (r_d.state != ST_RACC);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state   <= ST_IDLE;
            r_q.last_rd <= 1'b0;
            r_q.cs_n    <= 1'b1;
            r_q.we_n    <= 1'b1;
            r_q.oe_n    <= 1'b1;
            r_q.ready   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cs_n  = r_q.cs_n;
    assign we_n  = r_q.we_n;
    assign oe_n  = r_q.oe_n;
    assign ready = r_q.ready;

    // Phase-length observers for the properties below.
    localparam logic [15:0] ASU16  = 16'(T_ASU);
    localparam logic [15:0] WPL16  = 16'(WPLEN);
    localparam logic [15:0] REC16  = 16'(T_REC);
    localparam logic [15:0] ACC16  = 16'(T_ACC);
    localparam logic [15:0] TRN16  = 16'(T_TURN);

    logic [15:0] obs_asu_q, obs_wl_q, obs_rec_q, obs_ol_q, obs_oeh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            obs_asu_q <= '0;
            obs_wl_q  <= '0;
            obs_rec_q <= '0;
            obs_ol_q  <= '0;
            obs_oeh_q <= 16'hFFFF;
        end else begin
            if (r_q.cs_n) begin
                obs_asu_q <= '0;
                obs_wl_q  <= '0;
                obs_rec_q <= '0;
            end else if (!r_q.we_n) begin
                obs_wl_q <= obs_wl_q + 16'd1;
            end else if (obs_wl_q == '0) begin
                obs_asu_q <= obs_asu_q + 16'd1;
            end else begin
                obs_rec_q <= obs_rec_q + 16'd1;
            end
            if (r_q.oe_n) begin
                obs_ol_q <= '0;
                if (obs_oeh_q != 16'hFFFF) obs_oeh_q <= obs_oeh_q + 16'd1;
            end else begin
                obs_ol_q  <= obs_ol_q + 16'd1;
                obs_oeh_q <= '0;
            end
        end
    end

    assert_asu_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_q.we_n) |-> (obs_asu_q >= ASU16));

    assert_wp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.we_n) |-> (obs_wl_q >= WPL16));

    assert_rec_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(r_q.cs_n) && (obs_wl_q != '0)) |-> (obs_rec_q >= REC16));

    assert_oe_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.we_n |-> r_q.oe_n);

    assert_we_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.we_n |-> !r_q.cs_n);

    assert_acc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.oe_n) |-> (obs_ol_q >= ACC16));

    assert_ready_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.ready |=> !r_q.ready);

    assert_turn_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_q.we_n) |-> (obs_oeh_q >= TRN16));

endmodule

// File: rtl/sram_req_hold.sv
module sram_req_hold #(
    parameter int AW = 22,
    parameter int DW = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          accept_wr,
    input  logic          capture,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] mem_din,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_dout,
    output logic [DW-1:0] rdata
);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] dout;
        logic [DW-1:0] rdat;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (accept) begin
            h_d.addr = addr;
            if (accept_wr) h_d.dout = wdata;
        end
        if (capture) h_d.rdat = mem_din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    assign mem_addr = h_q.addr;
    assign mem_dout = h_q.dout;
    assign rdata    = h_q.rdat;

endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl #(
    parameter int AW     = 22,
    parameter int DW     = 1,
    parameter int T_ASU  = 1,
    parameter int T_WP   = 1,
    parameter int T_DSU  = 1,
    parameter int T_REC  = 1,
    parameter int T_ACC  = 2,
    parameter int T_TURN = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          ready,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_dout,
    input  logic [DW-1:0] mem_din,
    output logic          mem_cs_n,
    output logic          mem_we_n,
    output logic          mem_oe_n
);

    localparam int WPLEN = (T_WP > T_DSU) ? T_WP : T_DSU;
    localparam int M1    = (T_ASU > WPLEN) ? T_ASU : WPLEN;
    localparam int M2    = (T_REC > T_ACC) ? T_REC : T_ACC;
    localparam int M3    = (M1 > M2) ? M1 : M2;
    localparam int MAXT  = (M3 > T_TURN) ? M3 : T_TURN;
    localparam int CW    = $clog2(MAXT + 1);

    logic          tmr_load, tmr_expire, accept, capture;
    logic [CW-1:0] tmr_val;

    sram_phase_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expire   (tmr_expire)
    );

    sram_seq_fsm #(
        .T_ASU (T_ASU), .T_WP (T_WP), .T_DSU (T_DSU), .T_REC (T_REC),
        .T_ACC (T_ACC), .T_TURN (T_TURN), .CW (CW)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .we         (we),
        .tmr_expire (tmr_expire),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .accept     (accept),
        .capture    (capture),
        .cs_n       (mem_cs_n),
        .we_n       (mem_we_n),
        .oe_n       (mem_oe_n),
        .ready      (ready)
    );

    sram_req_hold #(.AW(AW), .DW(DW)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .accept_wr (we),
        .capture   (capture),
        .addr      (addr),
        .wdata     (wdata),
        .mem_din   (mem_din),
        .mem_addr  (mem_addr),
        .mem_dout  (mem_dout),
        .rdata     (rdata)
    );

    assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> ($stable(mem_addr) && $stable(mem_dout)));

    assert_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> mem_cs_n);

endmodule

// File: tb/sram_cycle_ctrl_bench.sv
module sram_cycle_ctrl_bench;

    localparam int TA = 2, TW = 3, TD = 4, TR = 2, TC = 3, TT = 2;
    localparam int WPL = (TW > TD) ? TW : TD;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req = 1'b0, we = 1'b0;
    logic [7:0] addr = '0, wdata = '0;
    logic [7:0] rdata, mem_addr, mem_dout, mem_din;
    logic       ready, mem_cs_n, mem_we_n, mem_oe_n;

    always #5 clk = ~clk;

    sram_cycle_ctrl #(
        .AW(8), .DW(8), .T_ASU(TA), .T_WP(TW), .T_DSU(TD),
        .T_REC(TR), .T_ACC(TC), .T_TURN(TT)
    ) u_sram_cycle_ctrl (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ready(ready), .mem_addr(mem_addr),
        .mem_dout(mem_dout), .mem_din(mem_din), .mem_cs_n(mem_cs_n),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n)
    );

    // Memory model: write on write-enable rise, read valid after TC-1 edges.
    logic [7:0] mem [256];
    logic       we_prev = 1'b1;
    int         rcnt = 0;
    initial for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    always @(posedge clk) begin
        if (!mem_cs_n && mem_we_n && !we_prev) mem[mem_addr] <= mem_dout;
        we_prev <= mem_we_n;
        if (!mem_cs_n && !mem_oe_n && mem_we_n) rcnt <= rcnt + 1;
        else rcnt <= 0;
    end
    assign mem_din = (rcnt >= TC - 1) ? mem[mem_addr] : 8'hA5;

    // Strobe phase monitor.
    int m_a = 0, m_w = 0, m_r = 0, m_ol = 0;
    bit m_moved = 0, m_seen = 0;
    logic [7:0] m_addr, m_dat;
    always @(posedge clk) begin
        if (mem_cs_n || !rst_n) begin
            m_a = 0; m_w = 0; m_r = 0; m_ol = 0; m_moved = 0; m_seen = 0;
        end else begin
            if (!mem_we_n) m_w++;
            else if (m_w == 0) m_a++;
            else m_r++;
            if (!mem_oe_n) m_ol++;
            if (m_seen && (mem_addr != m_addr || mem_dout != m_dat)) m_moved = 1;
            m_addr = mem_addr; m_dat = mem_dout; m_seen = 1;
        end
    end

    int checks = 0, failures = 0, cycles = 0;
    bit prev_rd = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic do_op(input logic w, input logic [7:0] a, input logic [7:0] d,
                         input logic [7:0] exp);
        int  lat;
        int  exp_lat;
        bit  turn;
        turn    = w && prev_rd;
        exp_lat = w ? ((turn ? TT : 0) + TA + WPL + TR + 1) : (TC + 1);
        req = 1'b1; we = w; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0;
        lat = 1;
        chk(mem_cs_n == turn, turn ? "R8 turnaround cs" : "R7 strobes next cycle",
            int'(mem_cs_n), int'(turn));
        while (!ready && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == exp_lat, w ? (turn ? "R8 latency" : "R3 latency") : "R5 latency",
            lat, exp_lat);
        chk(mem_cs_n == 1'b1, "R7 cs high at ready", int'(mem_cs_n), 1);
        if (w) begin
            chk(m_a == TA, "R3 setup phase", m_a, TA);
            chk(m_w == WPL, "R3 pulse phase", m_w, WPL);
            chk(m_r == TR, "R3 recovery phase", m_r, TR);
            chk(!m_moved, "R3 addr/data hold", int'(m_moved), 0);
            chk(m_ol == 0, "R4 oe during write", m_ol, 0);
        end else begin
            chk(rdata == exp, "R5 read data", int'(rdata), int'(exp));
            chk(m_ol == TC, "R5 access phase", m_ol, TC);
            chk(m_w == 0, "R5 no write pulse", m_w, 0);
        end
        prev_rd = !w;
    endtask

    localparam int NV = 14;
    localparam logic [24:0] VEC [NV] = '{
        {1'b1, 8'h10, 8'h11, 8'h00},
        {1'b1, 8'h20, 8'h22, 8'h00},
        {1'b1, 8'hFF, 8'h33, 8'h00},
        {1'b1, 8'h00, 8'h44, 8'h00},
        {1'b0, 8'h10, 8'h00, 8'h11},
        {1'b0, 8'h20, 8'h00, 8'h22},
        {1'b1, 8'h10, 8'h55, 8'h00},
        {1'b0, 8'h10, 8'h00, 8'h55},
        {1'b0, 8'hFF, 8'h00, 8'h33},
        {1'b0, 8'h00, 8'h00, 8'h44},
        {1'b1, 8'h20, 8'h66, 8'h00},
        {1'b1, 8'h21, 8'h77, 8'h00},
        {1'b0, 8'h20, 8'h00, 8'h66},
        {1'b0, 8'h21, 8'h00, 8'h77}
    };

    initial begin
        int nready;
        logic [7:0] held;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(mem_cs_n && mem_we_n && mem_oe_n, "R1 strobes in reset",
            int'({mem_cs_n, mem_we_n, mem_oe_n}), 7);
        chk(!ready, "R1 ready in reset", int'(ready), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_cs_n && mem_we_n && mem_oe_n, "R1 strobes after reset",
            int'({mem_cs_n, mem_we_n, mem_oe_n}), 7);
        chk(!ready, "R1 ready after reset", int'(ready), 0);

        // Vector table, issued back to back.
        for (int i = 0; i < NV; i++) begin
            do_op(VEC[i][24], VEC[i][23:16], VEC[i][15:8], VEC[i][7:0]);
        end

        // R6: ready is one cycle wide, idle after.
        @(negedge clk);
        chk(!ready, "R6 ready single cycle", int'(ready), 0);
        held = rdata;

        // R6: rdata held across a write.
        do_op(1'b1, 8'h30, 8'h5A, 8'h00);
        chk(rdata == held, "R6 rdata held", int'(rdata), int'(held));

        // R2: request during a write is ignored.
        @(negedge clk);
        req = 1'b1; we = 1'b1; addr = 8'h40; wdata = 8'h12;
        @(negedge clk);
        req = 1'b0;
        repeat (2) @(negedge clk);
        req = 1'b1; we = 1'b1; addr = 8'h41; wdata = 8'h99;
        @(negedge clk);
        req = 1'b0;
        nready = 0;
        for (int k = 0; k < 25; k++) begin
            if (ready) nready++;
            @(negedge clk);
        end
        chk(nready == 1, "R2 one ready only", nready, 1);
        prev_rd = 0;
        do_op(1'b0, 8'h41, 8'h00, 8'h00);
        do_op(1'b0, 8'h40, 8'h00, 8'h12);

        // R8: read then write with gap still turns around.
        repeat (3) @(negedge clk);
        do_op(1'b1, 8'h41, 8'hC3, 8'h00);
        do_op(1'b0, 8'h41, 8'h00, 8'hC3);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule